// File: doc/BRIEF.md
# Multi-PHY Cell-Available Status Responder

This block is the PHY-side status logic of a multi-port cell bus. It serves four ports. Each port provides a transmit flag meaning "room for one more cell" and a receive flag meaning "a whole cell is waiting". The ATM layer reads these flags in one of three ways:

- **Direct:** one dedicated line pair per port.
- **Single-line:** one shared line pair, answered for whichever port address is polled.
- **Grouped:** the device's four ports form one group of the eight. Polling any address in that group makes all four lines answer at once.

Each status line has an output enable that models a tri-state driver. The enable is raised only when this device owns the polled address.

The block also decides which port owns the cell bus for transfers. It supports three bus arrangements: one 8-bit bus, one 16-bit bus, or two independent 8-bit lanes.

- In the single-bus arrangements, lane A addresses all four ports and lane B is inert.
- In the dual-lane arrangement, lane A serves ports 0 and 1, and lane B serves ports 2 and 3. Each lane has its own address, enable strobe, selection and status line.

The status and selection logic is the same for both single-bus widths. Only the payload width, which lies outside this block, differs.

A port address is 5 bits wide: `{group[2:0], port[1:0]}`. The device answers only when `group` equals its configured base group. The all-ones address 5'h1F is the null address.

Polling takes two cycles. The address is presented in one cycle, and the status lines carry the answer in the next cycle. At that rate, a 53-cycle cell time allows more than twenty ports to be polled.

Top module: `mphy_status_responder`

## Requirements
- R1: The status mode, bus mode and base group are captured on every clock edge while `rst_n` is low. Changes to these inputs while `rst_n` is high have no effect.
- R2: Status mode code 0 (direct) drives all four lines of each direction with output enable high. Line i carries port i's flag as sampled on the previous clock edge, and the polled addresses have no effect.
- R3: A polled address is accepted only when its bits [4:2] equal the base group. Bits [1:0] of the address give the port number.
- R4: In status mode code 1 (single-line), line L answers lane L's address with the flag of port `addr[1:0]`, one cycle after the address is presented. Line L is enabled only if lane L owns that port. Lines 2 and 3 are never enabled in this mode.
- R5: In status mode code 2 (grouped), any accepted address on a lane enables every line that lane owns. Each enabled line i carries port i's flag, one cycle after the address.
- R6: Address 5'h1F never enables a status line and never selects a port, even when the base group is 7.
- R7: In bus mode code 2 (dual), lane A owns ports 0 and 1 (and lines 0 and 1), and lane B owns ports 2 and 3 (and lines 2 and 3).
- R8: In bus mode code 0 (single 8-bit) and code 1 (single 16-bit), lane A owns all four ports and all four lines. Lane B never selects a port and never enables a line.
- R9: A lane's selection loads port `addr[1:0]` and sets its valid flag on the clock edge where the enable strobe is low, provided two conditions hold: the strobe was high on the previous edge, and the address sampled on that previous edge is accepted and owned by the lane. Otherwise the selection holds its value.
- R10: During reset, and on the first edge after reset, every status line, output enable and selection valid flag is low. A status line is low whenever its enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_stat_mode | input | 2 | Status mode: 0 direct, 1 single-line, 2 grouped |
| cfg_bus_mode | input | 2 | Bus mode: 0 single 8-bit, 1 single 16-bit, 2 dual lanes |
| cfg_base | input | 3 | This device's group number |
| tx_room | input | 4 | Per-port transmit space flags |
| rx_ready | input | 4 | Per-port receive cell flags |
| tx_addr_a | input | 5 | Transmit address, lane A |
| tx_enb_a_n | input | 1 | Transmit enable strobe, lane A, active low |
| tx_addr_b | input | 5 | Transmit address, lane B |
| tx_enb_b_n | input | 1 | Transmit enable strobe, lane B, active low |
| rx_addr_a | input | 5 | Receive address, lane A |
| rx_enb_a_n | input | 1 | Receive enable strobe, lane A, active low |
| rx_addr_b | input | 5 | Receive address, lane B |
| rx_enb_b_n | input | 1 | Receive enable strobe, lane B, active low |
| tx_clav | output | 4 | Transmit cell-available lines |
| tx_clav_oe | output | 4 | Transmit line drive enables |
| rx_clav | output | 4 | Receive cell-available lines |
| rx_clav_oe | output | 4 | Receive line drive enables |
| tx_sel_a | output | 2 | Selected transmit port, lane A |
| tx_sel_a_vld | output | 1 | Lane A transmit selection valid |
| tx_sel_b | output | 2 | Selected transmit port, lane B |
| tx_sel_b_vld | output | 1 | Lane B transmit selection valid |
| rx_sel_a | output | 2 | Selected receive port, lane A |
| rx_sel_a_vld | output | 1 | Lane A receive selection valid |
| rx_sel_b | output | 2 | Selected receive port, lane B |
| rx_sel_b_vld | output | 1 | Lane B receive selection valid |

## Verification
The hardest case to reach is base group 7 combined with the grouped or dual-lane mode. In that case port 3's natural address coincides with the null address, so ownership, group match and the null rule all meet on one code. The bench reaches it by sweeping each lane's full 32-address space under every status and bus mode, for base groups 0 and 7. While each sweep runs, the configuration inputs are deliberately driven to other values, to show that only the values captured in reset matter. Selection is then exercised with strobe high-then-low pairs for every port address and the null address. Each pair is followed by low-strobe cycles carrying a different address, which must leave the selection unchanged.

// File: rtl/mphy_status_responder.sv
module mphy_status_responder #(
  parameter int NPORT = 4,
  parameter int AW    = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               cfg_stat_mode,
  input  logic [1:0]               cfg_bus_mode,
  input  logic [AW-$clog2(NPORT)-1:0] cfg_base,
  input  logic [NPORT-1:0]         tx_room,
  input  logic [NPORT-1:0]         rx_ready,
  input  logic [AW-1:0]            tx_addr_a,
  input  logic                     tx_enb_a_n,
  input  logic [AW-1:0]            tx_addr_b,
  input  logic                     tx_enb_b_n,
  input  logic [AW-1:0]            rx_addr_a,
  input  logic                     rx_enb_a_n,
  input  logic [AW-1:0]            rx_addr_b,
  input  logic                     rx_enb_b_n,
  output logic [NPORT-1:0]         tx_clav,
  output logic [NPORT-1:0]         tx_clav_oe,
  output logic [NPORT-1:0]         rx_clav,
  output logic [NPORT-1:0]         rx_clav_oe,
  output logic [$clog2(NPORT)-1:0] tx_sel_a,
  output logic                     tx_sel_a_vld,
  output logic [$clog2(NPORT)-1:0] tx_sel_b,
  output logic                     tx_sel_b_vld,
  output logic [$clog2(NPORT)-1:0] rx_sel_a,
  output logic                     rx_sel_a_vld,
  output logic [$clog2(NPORT)-1:0] rx_sel_b,
  output logic                     rx_sel_b_vld
);
  localparam int PW = $clog2(NPORT);
  localparam int GW = AW - PW;
  localparam logic [AW-1:0] NULL_ADDR = '1;

  logic [1:0]    stat_q, bus_q;
  logic [GW-1:0] base_q;

  always_ff @(posedge clk)
    if (!rst_n) begin
      stat_q <= cfg_stat_mode;
      bus_q  <= cfg_bus_mode;
      base_q <= cfg_base;
    end

  wire       dual  = (bus_q == 2'd2);
  wire [1:0] smode = (stat_q == 2'd3) ? 2'd0 : stat_q;

  function automatic logic in_group(input logic [AW-1:0] a, input logic [GW-1:0] b);
    return (a != NULL_ADDR) && (a[AW-1:PW] == b);
  endfunction

  function automatic logic lane_has(input logic [AW-1:0] a, input logic ln,
                                    input logic dm, input logic [GW-1:0] b);
    if (dm) return in_group(a, b) && (a[PW-1] == ln);
    return in_group(a, b) && !ln;
  endfunction

  logic [NPORT-1:0] flag [2];
  logic [AW-1:0]    addr [2][2];
  logic             enbn [2][2];

  assign flag[0] = tx_room;
  assign flag[1] = rx_ready;
  assign addr[0][0] = tx_addr_a;  assign enbn[0][0] = tx_enb_a_n;
  assign addr[0][1] = tx_addr_b;  assign enbn[0][1] = tx_enb_b_n;
  assign addr[1][0] = rx_addr_a;  assign enbn[1][0] = rx_enb_a_n;
  assign addr[1][1] = rx_addr_b;  assign enbn[1][1] = rx_enb_b_n;

  for (genvar d = 0; d < 2; d++) begin : g_dir
    logic [NPORT-1:0] nclav, noe, clav_q, oe_q;

    always_comb begin
      logic ln;
      nclav = '0;
      noe   = '0;
      case (smode)
        2'd1:
          for (int l = 0; l < 2; l++)
            if (lane_has(addr[d][l], 1'(l), dual, base_q)) begin
              noe[l]   = 1'b1;
              nclav[l] = flag[d][addr[d][l][PW-1:0]];
            end
        2'd2:
          for (int i = 0; i < NPORT; i++) begin
            ln = dual && (i >= NPORT/2);
            if (in_group(addr[d][ln], base_q) && (dual || !ln)) begin
              noe[i]   = 1'b1;
              nclav[i] = flag[d][i];
            end
          end
        default: begin
          noe   = '1;
          nclav = flag[d];
        end
      endcase
    end

    always_ff @(posedge clk)
      if (!rst_n) begin
        clav_q <= '0;
        oe_q   <= '0;
      end else begin
        clav_q <= nclav;
        oe_q   <= noe;
      end

    for (genvar l = 0; l < 2; l++) begin : g_lane
      logic [AW-1:0] addr_q;
      logic          enb_q, selv_q;
      logic [PW-1:0] sel_q;

      always_ff @(posedge clk)
        if (!rst_n) begin
          addr_q <= NULL_ADDR;
          enb_q  <= 1'b0;
          sel_q  <= '0;
          selv_q <= 1'b0;
        end else begin
          addr_q <= addr[d][l];
          enb_q  <= enbn[d][l];
          if (enb_q && !enbn[d][l] && lane_has(addr_q, 1'(l), dual, base_q)) begin
            sel_q  <= addr_q[PW-1:0];
            selv_q <= 1'b1;
          end
        end
    end
  end

  assign tx_clav      = g_dir[0].clav_q & g_dir[0].oe_q;
  assign tx_clav_oe   = g_dir[0].oe_q;
  assign rx_clav      = g_dir[1].clav_q & g_dir[1].oe_q;
  assign rx_clav_oe   = g_dir[1].oe_q;
  assign tx_sel_a     = g_dir[0].g_lane[0].sel_q;
  assign tx_sel_a_vld = g_dir[0].g_lane[0].selv_q;
  assign tx_sel_b     = g_dir[0].g_lane[1].sel_q;
  assign tx_sel_b_vld = g_dir[0].g_lane[1].selv_q;
  assign rx_sel_a     = g_dir[1].g_lane[0].sel_q;
  assign rx_sel_a_vld = g_dir[1].g_lane[0].selv_q;
  assign rx_sel_b     = g_dir[1].g_lane[1].sel_q;
  assign rx_sel_b_vld = g_dir[1].g_lane[1].selv_q;
endmodule

// File: rtl/mphy_status_chk.sv
module mphy_status_chk #(
  parameter int NPORT = 4,
  parameter int AW    = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [1:0]               stat_q,
  input logic [1:0]               bus_q,
  input logic [AW-1:0]            tx_addr_a,
  input logic [AW-1:0]            tx_addr_b,
  input logic                     tx_enb_a_n,
  input logic [NPORT-1:0]         tx_clav_oe,
  input logic [NPORT-1:0]         rx_clav_oe,
  input logic [$clog2(NPORT)-1:0] tx_sel_a,
  input logic                     tx_sel_a_vld,
  input logic [$clog2(NPORT)-1:0] tx_sel_b,
  input logic                     tx_sel_b_vld,
  input logic                     rx_sel_b_vld
);
  localparam int PW = $clog2(NPORT);

  // R1
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(stat_q) && $stable(bus_q));

  // R2
  direct_all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q == 2'd0 |=> (&tx_clav_oe) && (&rx_clav_oe));

  // R4
  single_line_upper_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q == 2'd1 |=> tx_clav_oe[NPORT-1:2] == '0 && rx_clav_oe[NPORT-1:2] == '0);

  // R6
  null_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q == 2'd1 || stat_q == 2'd2) && (&tx_addr_a) && (&tx_addr_b) |=> tx_clav_oe == '0);

  // R7
  dual_lane_b_ports_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sel_b_vld |-> tx_sel_b[PW-1]);

  // R7
  dual_lane_a_ports_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_q == 2'd2 && tx_sel_a_vld |-> !tx_sel_a[PW-1]);

  // R8
  lane_b_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_q != 2'd2 |-> !tx_sel_b_vld && !rx_sel_b_vld);

  // R9
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_enb_a_n |=> $stable(tx_sel_a) && $stable(tx_sel_a_vld));
endmodule

bind mphy_status_responder mphy_status_chk #(.NPORT(NPORT), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .stat_q(stat_q), .bus_q(bus_q),
  .tx_addr_a(tx_addr_a), .tx_addr_b(tx_addr_b), .tx_enb_a_n(tx_enb_a_n),
  .tx_clav_oe(tx_clav_oe), .rx_clav_oe(rx_clav_oe),
  .tx_sel_a(tx_sel_a), .tx_sel_a_vld(tx_sel_a_vld),
  .tx_sel_b(tx_sel_b), .tx_sel_b_vld(tx_sel_b_vld),
  .rx_sel_b_vld(rx_sel_b_vld)
);

// File: tb/sim_mphy_status_responder.sv
module sim_mphy_status_responder;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [1:0] cfg_stat_mode = 0, cfg_bus_mode = 0;
  logic [2:0] cfg_base = 0;
  logic [3:0] tx_room = 0, rx_ready = 0;
  logic [4:0] tx_addr_a = 5'h1F, tx_addr_b = 5'h1F, rx_addr_a = 5'h1F, rx_addr_b = 5'h1F;
  logic tx_enb_a_n = 1, tx_enb_b_n = 1, rx_enb_a_n = 1, rx_enb_b_n = 1;
  logic [3:0] tx_clav, tx_clav_oe, rx_clav, rx_clav_oe;
  logic [1:0] tx_sel_a, tx_sel_b, rx_sel_a, rx_sel_b;
  logic tx_sel_a_vld, tx_sel_b_vld, rx_sel_a_vld, rx_sel_b_vld;

  int tests = 0, fails = 0;
  int st, bm, bs;
  int exp_sel [2];
  logic exp_vld [2];

  always #(PERIOD/2) clk = ~clk;

  mphy_status_responder u0 (.*);

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic owns(int a, int l);
    if (a == 31 || a / 4 != bs) return 0;
    if (bm == 2) return (a % 4) / 2 == l;
    return l == 0;
  endfunction

  function automatic logic [7:0] expect_stat(int aa, int ab, logic [3:0] f);
    logic [3:0] oe = 0, cv = 0;
    int a [2];
    a[0] = aa; a[1] = ab;
    if (st == 1) begin
      for (int l = 0; l < 2; l++)
        if (owns(a[l], l)) begin oe[l] = 1; cv[l] = f[a[l] % 4]; end
    end else if (st == 2) begin
      for (int i = 0; i < 4; i++) begin
        int l = (bm == 2) ? i / 2 : 0;
        if (a[l] != 31 && a[l] / 4 == bs) begin oe[i] = 1; cv[i] = f[i]; end
      end
    end else begin
      oe = 4'hF; cv = f;
    end
    return {oe, cv};
  endfunction

  task automatic poll(int aa, int ab, logic [3:0] ft, logic [3:0] fr);
    logic [7:0] et, er;
    tx_addr_a = 5'(aa); rx_addr_a = 5'(aa);
    tx_addr_b = 5'(ab); rx_addr_b = 5'(ab);
    tx_room = ft; rx_ready = fr;
    cfg_stat_mode = 2'((st + 1) % 3); cfg_bus_mode = 2'((bm + 2) % 3); cfg_base = 3'(bs ^ 5);
    step();
    et = expect_stat(aa, ab, ft);
    er = expect_stat(aa, ab, fr);
    // R1 R2 R3 R4 R5 R6 R7 R8 R10
    check($sformatf("R2/R4/R5 tx st%0d bm%0d bs%0d a%0d b%0d", st, bm, bs, aa, ab), {tx_clav_oe, tx_clav}, et);
    check($sformatf("R3/R6/R7 rx st%0d bm%0d bs%0d a%0d b%0d", st, bm, bs, aa, ab), {rx_clav_oe, rx_clav}, er);
  endtask

  task automatic check_sel(string req);
    check({req, " tx lane A"}, {tx_sel_a_vld, tx_sel_a}, exp_vld[0] ? 4 + exp_sel[0] : {1'b0, tx_sel_a});
    check({req, " rx lane A"}, {rx_sel_a_vld, rx_sel_a}, exp_vld[0] ? 4 + exp_sel[0] : {1'b0, rx_sel_a});
    check({req, " tx lane B"}, {tx_sel_b_vld, tx_sel_b}, exp_vld[1] ? 4 + exp_sel[1] : {1'b0, tx_sel_b});
    check({req, " rx lane B"}, {rx_sel_b_vld, rx_sel_b}, exp_vld[1] ? 4 + exp_sel[1] : {1'b0, rx_sel_b});
  endtask

  task automatic set_lane(int l, int a, logic e);
    if (l == 0) begin tx_addr_a = 5'(a); rx_addr_a = 5'(a); tx_enb_a_n = e; rx_enb_a_n = e; end
    else        begin tx_addr_b = 5'(a); rx_addr_b = 5'(a); tx_enb_b_n = e; rx_enb_b_n = e; end
  endtask

  task automatic select_try(int l, int a);
    set_lane(l, a, 1);
    step();
    set_lane(l, 31, 0);
    step();
    if (owns(a, l)) begin exp_sel[l] = a % 4; exp_vld[l] = 1; end
    // R9 R6 R7 R8
    check_sel($sformatf("R9 select l%0d a%0d bm%0d", l, a, bm));
    set_lane(l, bs * 4 + ((a + 1) % 4), 0);
    step();
    step();
    check_sel($sformatf("R9 hold l%0d bm%0d", l, bm));
    set_lane(l, 31, 1);
    step();
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int s = 0; s < 3; s++)
      for (int b = 0; b < 3; b++)
        for (int k = 0; k < 2; k++) begin
          st = s; bm = b; bs = k ? 7 : 0;
          @(negedge clk);
          rst_n = 0;
          cfg_stat_mode = 2'(st); cfg_bus_mode = 2'(bm); cfg_base = 3'(bs);
          tx_room = 4'hF; rx_ready = 4'hF;
          set_lane(0, 31, 1); set_lane(1, 31, 1);
          step(); step();
          // R10
          check("R10 reset outputs", {tx_clav, tx_clav_oe, rx_clav, rx_clav_oe,
                tx_sel_a_vld, tx_sel_b_vld, rx_sel_a_vld, rx_sel_b_vld}, 0);
          rst_n = 1;
          exp_vld[0] = 0; exp_vld[1] = 0; exp_sel[0] = 0; exp_sel[1] = 0;
          for (int a = 0; a < 32; a++) begin
            poll(a, 31, 4'((a * 5 + 3) % 16), 4'((a * 11 + 6) % 16));
            poll(31, a, 4'((a * 7 + 1) % 16), 4'((a * 3 + 9) % 16));
            poll(a, 31 - a, 4'(a % 16), 4'(15 - a % 16));
          end
          for (int l = 0; l < 2; l++) begin
            for (int p = 0; p < 4; p++) select_try(l, bs * 4 + p);
            select_try(l, 31);
            select_try(l, ((bs + 1) % 8) * 4 + 1);
          end
        end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule